// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarms

This block is a real-time clock peripheral behind a simple register bus. A slow tick strobe (nominally 32 kHz) drives a fractional accumulator that advances a milliseconds counter, and each milliseconds wrap advances a 32-bit seconds counter. The live counters are not read directly. Once every eight ticks the block publishes them to bus-visible copies. The last tick slot of each group of eight is a busy interval, and any write that arrives during it is discarded.

Software gets a coherent time pair as follows. A read strobe on the milliseconds register freezes the visible seconds value into a shadow register, so reading milliseconds and then the shadow gives two values taken at the same moment. Two seconds alarms and one milliseconds alarm raise bits in a write-one-to-clear status register. A mask register selects which status bits drive the active-high level interrupt.

Top module: `sec_rtc`

## Requirements
- R1: After reset, every register reads zero, busy reads zero and `irq` is low.
- R2: Bit 0 of the busy register (0x004) reads 1 during the eighth tick slot of every group of eight ticks. It stays 1 until the next tick arrives and reads 0 in the other seven slots.
- R3: The visible seconds (0x008) and milliseconds (0x010) change only on the tick that ends a busy slot, or on an accepted seconds write. At that tick they load the live values that result from that tick.
- R4: A read strobe on 0x010 loads the shadow register (0x00C) with the visible seconds in the same access. Addressing without the strobe leaves the shadow unchanged.
- R5: An accepted write to 0x008 loads the live and visible seconds with the written data. It clears the milliseconds and the fractional accumulator to zero, and a tick in the same cycle is ignored.
- R6: Reads are accepted at any time. A write presented while busy is 1 is discarded.
- R7: Each tick adds MS_PER_S to the accumulator, and milliseconds advance by one whenever the accumulator reaches TICK_HZ. Milliseconds wrap from MS_PER_S-1 to 0 and increment the seconds counter, which wraps modulo 2^32. After n ticks from a seconds load, milliseconds equal floor(n*MS_PER_S/TICK_HZ) for n < TICK_HZ, and seconds have advanced by one at n = TICK_HZ.
- R8: Status bit 0 (alarm register 0x014) and status bit 1 (alarm register 0x018) are set on the cycle in which the seconds counter steps into a value equal to that alarm. An alarm value of zero never matches.
- R9: Status bit 2 is set on the cycle in which the milliseconds counter steps into a value equal to the nonzero value in 0x01C.
- R10: Writing 1 to a bit of the status register (0x02C) clears it, and writing 0 leaves it unchanged. An alarm set in the same cycle as a clear wins. Bits 3 and 4 are never set.
- R11: `irq` is high exactly while some status bit is set with the same bit set in the mask register (0x028).
- R12: The alarm registers read back their written values at their own offsets, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe from the slow time base |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; has a side effect only on 0x010 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, active high |

## Verification
The seconds alarm and a write-one-to-clear on the status register can land on the same clock edge. The bench provokes this by first aligning the copy phase so the target edge falls outside the busy slot. It then loads seconds with the tick held low and counts exactly TICK_HZ-1 ticks. On the next edge it presents the final tick together with a status write of all ones. The check requires the alarm bit to read back set, no other bit set and the interrupt still held low by a zero mask.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int DATA_W   = 32;
   localparam int ADDR_W   = 8;
   localparam int N_SEC_ALM = 2;
   localparam int N_SRC     = 5;
   localparam int SRC_MS_ALM = 2;

   localparam logic [ADDR_W-1:0] OFS_BUSY   = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_SEC    = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_SHADOW = 8'h0C;
   localparam logic [ADDR_W-1:0] OFS_MS     = 8'h10;
   localparam logic [ADDR_W-1:0] OFS_ALM0   = 8'h14;
   localparam logic [ADDR_W-1:0] OFS_MSALM  = 8'h1C;
   localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h28;
   localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h2C;

   function automatic logic [ADDR_W-1:0] sec_alm_ofs(input int idx);
      return OFS_ALM0 + ADDR_W'(4 * idx);
   endfunction
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
   parameter int TICK_HZ    = 32768,
   parameter int MS_PER_S   = 1000,
   parameter int SEC_W      = 32,
   parameter int COPY_TICKS = 8,
   parameter int MS_W       = 10,
   parameter int ACC_W      = 17,
   parameter int PH_W       = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [SEC_W-1:0] load_val,
   output logic [SEC_W-1:0] sec_d,
   output logic [MS_W-1:0]  ms_d,
   output logic             ms_step,
   output logic             sec_step,
   output logic             busy,
   output logic             copy_evt
);
   localparam logic [ACC_W-1:0] ACC_TOP = ACC_W'(TICK_HZ);
   localparam logic [ACC_W-1:0] ACC_INC = ACC_W'(MS_PER_S);
   localparam logic [MS_W-1:0]  MS_LAST = MS_W'(MS_PER_S - 1);
   localparam logic [MS_W-1:0]  MS_ONE  = MS_W'(1);
   localparam logic [SEC_W-1:0] SEC_ONE = SEC_W'(1);
   localparam logic [PH_W-1:0]  PH_LAST = PH_W'(COPY_TICKS - 1);
   localparam logic [PH_W-1:0]  PH_ONE  = PH_W'(1);

   logic [ACC_W-1:0] acc_q, acc_d, acc_sum;
   logic [MS_W-1:0]  ms_q;
   logic [SEC_W-1:0] sec_q;
   logic [PH_W-1:0]  ph_q, ph_d;
   logic             ms_wrap;

   always_comb begin
      acc_sum  = acc_q + ACC_INC;
      busy     = (ph_q == PH_LAST);
      copy_evt = tick & busy;
      ph_d     = tick ? (busy ? '0 : ph_q + PH_ONE) : ph_q;
      ms_step  = tick & ~load & (acc_sum >= ACC_TOP);
      ms_wrap  = (ms_q == MS_LAST);
      sec_step = ms_step & ms_wrap;

      if (load)         acc_d = '0;
      else if (ms_step) acc_d = acc_sum - ACC_TOP;
      else if (tick)    acc_d = acc_sum;
      else              acc_d = acc_q;

      if (load)         ms_d = '0;
      else if (ms_step) ms_d = ms_wrap ? '0 : ms_q + MS_ONE;
      else              ms_d = ms_q;

      if (load)          sec_d = load_val;
      else if (sec_step) sec_d = sec_q + SEC_ONE;
      else               sec_d = sec_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ms_q  <= '0;
         sec_q <= '0;
         ph_q  <= '0;
      end else begin
         acc_q <= acc_d;
         ms_q  <= ms_d;
         sec_q <= sec_d;
         ph_q  <= ph_d;
      end
   end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int SEC_W  = 32,
   parameter int MS_W   = 10,
   parameter int N_ALM  = 2,
   parameter int N_SRC  = 5
)(
   input  logic                        sec_step,
   input  logic [SEC_W-1:0]            sec_d,
   input  logic                        ms_step,
   input  logic [MS_W-1:0]             ms_d,
   input  logic [N_ALM-1:0][SEC_W-1:0] sec_alm,
   input  logic [MS_W-1:0]             ms_alm,
   output logic [N_SRC-1:0]            hits
);
   localparam int PAD_W = N_SRC - N_ALM - 1;

   logic [N_ALM-1:0] sec_hit;
   logic             ms_hit;

   genvar g;
   generate
      for (g = 0; g < N_ALM; g++) begin : g_sec_cmp
         assign sec_hit[g] = sec_step & (sec_alm[g] != '0) & (sec_d == sec_alm[g]);
      end
      if (PAD_W > 0) begin : g_pad
         assign hits = {{PAD_W{1'b0}}, ms_hit, sec_hit};
      end else begin : g_nopad
         assign hits = {ms_hit, sec_hit};
      end
   endgenerate

   assign ms_hit = ms_step & (ms_alm != '0) & (ms_d == ms_alm);
endmodule

// File: rtl/rtc_int_ctrl.sv
module rtc_int_ctrl #(
   parameter int N_SRC   = 5,
   parameter bit IRQ_REG = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_vec,
   input  logic             clr_we,
   input  logic [N_SRC-1:0] clr_vec,
   input  logic             mask_we,
   input  logic [N_SRC-1:0] mask_val,
   output logic [N_SRC-1:0] status_q,
   output logic [N_SRC-1:0] mask_q,
   output logic             irq
);
   logic [N_SRC-1:0] clr_eff;
   logic             irq_raw;

   assign clr_eff = clr_we ? clr_vec : '0;
   assign irq_raw = |(status_q & mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '0;
      end else begin
         status_q <= (status_q & ~clr_eff) | set_vec;
         if (mask_we) mask_q <= mask_val;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
   import rtc_pkg::*;
#(
   parameter int TICK_HZ    = 32768,
   parameter int MS_PER_S   = 1000,
   parameter int SEC_W      = 32,
   parameter int COPY_TICKS = 8,
   parameter bit IRQ_REG    = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int MS_W  = $clog2(MS_PER_S);
   localparam int ACC_W = $clog2(TICK_HZ + MS_PER_S) + 1;
   localparam int PH_W  = (COPY_TICKS > 2) ? $clog2(COPY_TICKS) : 1;

   generate
      if (MS_PER_S >= TICK_HZ) begin : g_chk_rate
         $error("sec_rtc: MS_PER_S must be below TICK_HZ");
      end
      if (SEC_W != DATA_W) begin : g_chk_sec
         $error("sec_rtc: SEC_W must equal the bus data width");
      end
      if (COPY_TICKS < 2) begin : g_chk_copy
         $error("sec_rtc: COPY_TICKS must be at least 2");
      end
   endgenerate

   logic                            busy, copy_evt, ms_step, sec_step;
   logic                            wr_ok, load_sec;
   logic [SEC_W-1:0]                sec_d;
   logic [MS_W-1:0]                 ms_d;
   logic [SEC_W-1:0]                vis_sec_q, shadow_q;
   logic [MS_W-1:0]                 vis_ms_q, msalm_q;
   logic [N_SEC_ALM-1:0][SEC_W-1:0] alm_q;
   logic [N_SRC-1:0]                alm_hits, status_q, mask_q;

   assign wr_ok    = bus_wr & ~busy;
   assign load_sec = wr_ok & (bus_addr == OFS_SEC);

   rtc_timebase #(
      .TICK_HZ(TICK_HZ), .MS_PER_S(MS_PER_S), .SEC_W(SEC_W),
      .COPY_TICKS(COPY_TICKS), .MS_W(MS_W), .ACC_W(ACC_W), .PH_W(PH_W)
   ) u_tb (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(load_sec),
      .load_val(bus_wdata[SEC_W-1:0]), .sec_d(sec_d), .ms_d(ms_d),
      .ms_step(ms_step), .sec_step(sec_step), .busy(busy), .copy_evt(copy_evt)
   );

   rtc_alarm_match #(
      .SEC_W(SEC_W), .MS_W(MS_W), .N_ALM(N_SEC_ALM), .N_SRC(N_SRC)
   ) u_alm (
      .sec_step(sec_step), .sec_d(sec_d), .ms_step(ms_step), .ms_d(ms_d),
      .sec_alm(alm_q), .ms_alm(msalm_q), .hits(alm_hits)
   );

   rtc_int_ctrl #(
      .N_SRC(N_SRC), .IRQ_REG(IRQ_REG)
   ) u_int (
      .clk(clk), .rst_n(rst_n), .set_vec(alm_hits),
      .clr_we(wr_ok & (bus_addr == OFS_STAT)), .clr_vec(bus_wdata[N_SRC-1:0]),
      .mask_we(wr_ok & (bus_addr == OFS_MASK)), .mask_val(bus_wdata[N_SRC-1:0]),
      .status_q(status_q), .mask_q(mask_q), .irq(irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vis_sec_q <= '0;
         vis_ms_q  <= '0;
         shadow_q  <= '0;
         msalm_q   <= '0;
         alm_q     <= '0;
      end else begin
         if (load_sec || copy_evt) begin
            vis_sec_q <= sec_d;
            vis_ms_q  <= ms_d;
         end
         if (bus_rd && (bus_addr == OFS_MS)) shadow_q <= vis_sec_q;
         if (wr_ok && (bus_addr == OFS_MSALM)) msalm_q <= bus_wdata[MS_W-1:0];
         for (int i = 0; i < N_SEC_ALM; i++) begin
            if (wr_ok && (bus_addr == sec_alm_ofs(i))) alm_q[i] <= bus_wdata[SEC_W-1:0];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_BUSY:   bus_rdata[0] = busy;
         OFS_SEC:    bus_rdata = DATA_W'(vis_sec_q);
         OFS_SHADOW: bus_rdata = DATA_W'(shadow_q);
         OFS_MS:     bus_rdata = DATA_W'(vis_ms_q);
         OFS_MSALM:  bus_rdata = DATA_W'(msalm_q);
         OFS_MASK:   bus_rdata = DATA_W'(mask_q);
         OFS_STAT:   bus_rdata = DATA_W'(status_q);
         default:    bus_rdata = '0;
      endcase
      for (int i = 0; i < N_SEC_ALM; i++) begin
         if (bus_addr == sec_alm_ofs(i)) bus_rdata = DATA_W'(alm_q[i]);
      end
   end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
   import rtc_pkg::*;
#(
   parameter int SEC_W    = 32,
   parameter int MS_W     = 10,
   parameter int MS_PER_S = 1000
)(
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              busy,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [N_SRC-1:0]  stat_wdata,
   input logic [SEC_W-1:0]  vis_sec,
   input logic [MS_W-1:0]   vis_ms,
   input logic [SEC_W-1:0]  shadow,
   input logic [N_SRC-1:0]  mask_q,
   input logic [N_SRC-1:0]  status_q,
   input logic [N_SRC-1:0]  hits,
   input logic              irq
);
   // R1: a cycle in reset leaves status empty and the interrupt low
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (status_q == '0 && !irq));

   // R2: the busy slot ends on the next tick
   p_busy_one_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick) |=> !busy);

   // R3: visible milliseconds hold except at a copy or an accepted seconds load
   p_vis_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(busy && tick) && !(bus_wr && !busy && bus_addr == OFS_SEC)) |=> $stable(vis_ms));

   // R4: a milliseconds read strobe freezes the visible seconds into the shadow
   p_shadow_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_MS) |=> (shadow == $past(vis_sec)));

   // R6: a mask write inside the busy slot is discarded
   p_drop_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_wr && bus_addr == OFS_MASK) |=> $stable(mask_q));

   // R7: visible milliseconds stay inside one second
   p_ms_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vis_ms < MS_W'(MS_PER_S));

   // R8: an alarm match lands in status bit 0
   p_alarm_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hits[0] |=> status_q[0]);

   // R10: clearing everything with no match pending empties status
   p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !busy && bus_addr == OFS_STAT && (&stat_wdata) && hits == '0)
      |=> (status_q == '0));

   // R11: a mask that has been zero for two cycles keeps the interrupt low
   p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0 && $past(mask_q) == '0) |-> !irq);
endmodule

bind sec_rtc rtc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy),
   .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .stat_wdata(bus_wdata[rtc_pkg::N_SRC-1:0]),
   .vis_sec(vis_sec_q), .vis_ms(vis_ms_q), .shadow(shadow_q),
   .mask_q(mask_q), .status_q(status_q), .hits(alm_hits), .irq(irq)
);

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;
   import rtc_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int TB_HZ      = 1024;
   localparam int TB_MS      = 1000;
   localparam logic [7:0] OFS_ALM1 = 8'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sec_rtc #(.TICK_HZ(TB_HZ), .MS_PER_S(TB_MS)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic t);
      tick = t;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step(1'b1);
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      bus_rd = 1'b1;
      #1;
      d = bus_rdata;
      step(1'b0);
      bus_rd = 1'b0;
   endtask

   task automatic wr_raw(input logic [7:0] a, input logic [31:0] d, input logic t);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      step(t);
      bus_wr    = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      logic [31:0] b;
      peek(OFS_BUSY, b);
      while (b[0]) begin
         step(1'b1);
         peek(OFS_BUSY, b);
      end
      wr_raw(a, d, 1'b0);
   endtask

   // leave the copy phase one tick past a copy, outside the busy slot
   task automatic align();
      logic [31:0] b;
      peek(OFS_BUSY, b);
      while (!b[0]) begin
         step(1'b1);
         peek(OFS_BUSY, b);
      end
      step(1'b1);
      step(1'b1);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      peek(OFS_BUSY, d);   chk("R1 busy", d, 0);
      peek(OFS_SEC, d);    chk("R1 seconds", d, 0);
      peek(OFS_SHADOW, d); chk("R1 shadow", d, 0);
      peek(OFS_MS, d);     chk("R1 millis", d, 0);
      peek(OFS_ALM0, d);   chk("R1 alarm0", d, 0);
      peek(OFS_ALM1, d);   chk("R1 alarm1", d, 0);
      peek(OFS_MSALM, d);  chk("R1 ms alarm", d, 0);
      peek(OFS_MASK, d);   chk("R1 mask", d, 0);
      peek(OFS_STAT, d);   chk("R1 status", d, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      peek(8'h20, d);      chk("R12 unmapped", d, 0);
   endtask

   task automatic t_busy();
      logic [31:0] d;
      int ones = 0;
      int bad = 0;
      for (int i = 0; i < 24; i++) begin
         peek(OFS_BUSY, d);
         if (d[0]) ones++;
         if (d[0] != ((i % 8) == 7)) bad++;
         step(1'b1);
      end
      chk("R2 busy count", ones, 3);
      chk("R2 busy placement", bad, 0);
   endtask

   task automatic t_copy();
      logic [31:0] d, b, prev;
      int n = 0;
      bit seen = 1'b0;
      wr(OFS_SEC, 32'd100);
      peek(OFS_SEC, d); chk("R5 seconds visible", d, 100);
      peek(OFS_MS, d);  chk("R5 millis cleared", d, 0);
      while (!seen) begin
         peek(OFS_BUSY, b);
         if (b[0]) begin
            peek(OFS_MS, d); chk("R3 held before copy", d, 0);
            seen = 1'b1;
         end
         step(1'b1);
         n++;
      end
      peek(OFS_MS, d); chk("R7 millis at copy", d, (n * TB_MS) / TB_HZ);
      prev = d;
      run(7);
      peek(OFS_MS, d); chk("R3 held between copies", d, prev);
      run(1);
      peek(OFS_MS, d); chk("R3 next copy", d, ((n + 8) * TB_MS) / TB_HZ);
   endtask

   task automatic t_drop();
      logic [31:0] b, d;
      peek(OFS_BUSY, b);
      while (!b[0]) begin
         step(1'b1);
         peek(OFS_BUSY, b);
      end
      wr_raw(OFS_MASK, 32'h1F, 1'b0);
      wr_raw(OFS_ALM0, 32'd55, 1'b0);
      wr_raw(OFS_SEC, 32'd999, 1'b0);
      peek(OFS_MASK, d); chk("R6 mask dropped", d, 0);
      peek(OFS_ALM0, d); chk("R6 alarm dropped", d, 0);
      peek(OFS_SEC, d);  chk("R6 seconds dropped", d, 100);
   endtask

   task automatic t_shadow();
      logic [31:0] d;
      peek(OFS_SHADOW, d); chk("R4 shadow untouched by address", d, 0);
      rd(OFS_MS, d);
      peek(OFS_SHADOW, d); chk("R4 shadow latched", d, 100);
   endtask

   task automatic t_ms_alarm();
      logic [31:0] d;
      wr(OFS_MASK, 32'h4);
      wr(OFS_MSALM, 32'd5);
      peek(OFS_MSALM, d); chk("R12 ms alarm readback", d, 5);
      wr(OFS_SEC, 32'd200);
      run(5);
      peek(OFS_STAT, d); chk("R9 not yet", d, 0);
      chk("R11 irq idle", {31'b0, irq}, 0);
      run(1);
      peek(OFS_STAT, d); chk("R9 ms alarm set", d, 4);
      chk("R11 irq raised", {31'b0, irq}, 1);
      wr(OFS_STAT, 32'h0);
      peek(OFS_STAT, d); chk("R10 zero write keeps", d, 4);
      wr(OFS_STAT, 32'h4);
      peek(OFS_STAT, d); chk("R10 one write clears", d, 0);
      chk("R11 irq dropped", {31'b0, irq}, 0);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      wr(OFS_MSALM, 32'd0);
      wr(OFS_MASK, 32'd0);
      wr(OFS_ALM0, 32'd301);
      wr(OFS_ALM1, 32'd0);
      peek(OFS_ALM0, d); chk("R12 alarm0 readback", d, 301);
      align();
      wr_raw(OFS_SEC, 32'd300, 1'b0);
      run(TB_HZ - 1);
      peek(OFS_STAT, d); chk("R8 alarm not early", d, 0);
      wr_raw(OFS_STAT, 32'h1F, 1'b1);
      peek(OFS_STAT, d); chk("R10 set beats clear", d, 1);
      chk("R11 masked irq", {31'b0, irq}, 0);
      wr(OFS_MASK, 32'h1);
      chk("R11 unmasked irq", {31'b0, irq}, 1);
      run(8);
      peek(OFS_SEC, d); chk("R7 seconds advanced", d, 301);
   endtask

   task automatic t_wrap();
      logic [31:0] d;
      wr(OFS_STAT, 32'h1F);
      peek(OFS_STAT, d); chk("R10 all cleared", d, 0);
      wr(OFS_MASK, 32'h3);
      wr(OFS_ALM0, 32'd0);
      wr(OFS_ALM1, 32'd1);
      peek(OFS_ALM1, d); chk("R12 alarm1 readback", d, 1);
      align();
      wr_raw(OFS_SEC, 32'hFFFF_FFFF, 1'b0);
      run(TB_HZ + 8);
      peek(OFS_SEC, d);  chk("R7 seconds wrap", d, 0);
      peek(OFS_STAT, d); chk("R8 zero alarm never", d, 0);
      chk("R11 irq quiet", {31'b0, irq}, 0);
      run(TB_HZ - 8);
      peek(OFS_STAT, d); chk("R8 alarm1 set", d, 2);
      chk("R11 irq alarm1", {31'b0, irq}, 1);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_busy();
      t_copy();
      t_drop();
      t_shadow();
      t_ms_alarm();
      t_collide();
      t_wrap();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule